// File: doc/BRIEF.md
# Vector Destination Merge with Tail and Mask Policies

This block assembles the value written back to a vector destination register. For every element position it decides whether the freshly computed result goes in, whether the previous contents of the destination survive, or whether a fixed fill pattern replaces them. The decision depends on the granted vector length, the element width chosen at run time, the per-element predicate bits, whether the instruction uses predication at all, and two independent policy bits: one for elements past the vector length and one for predicated-off elements inside it.

Beside the merged register value it produces one write enable per byte and a one-bit-per-element active vector. A load/store unit can use these to suppress memory writes for inactive positions. A whole-register flag turns off all length and predicate handling, so that the full register width is taken from the new result. Results are registered and appear one clock after the request.

Top module: `sxm_merge`

## Requirements
- R1: Element i is a body element when i is less than the effective length, and a tail element otherwise. The effective length is the requested length clamped to the element count VLEN/SEW. For example, length 5 with 8 elements makes elements 5 to 7 tail.
- R2: With predication enabled, a body element is active only when its predicate bit (bit i of the predicate input) is 1. With predication disabled, every body element is active.
- R3: With the tail policy bit at 0 (keep), every byte of a tail element equals the old destination byte, and its write enable is 0.
- R4: With the tail policy bit at 1 (fill), every byte of a tail element is 0xFF, and its write enable is 1.
- R5: With the predicate policy bit at 0 (keep), an inactive body element keeps the old destination value, and its write enables are 0.
- R6: With the predicate policy bit at 1 (fill), an inactive body element becomes all ones, and its write enables are 1.
- R7: Every active element takes the new result, with its write enables at 1.
- R8: With the whole-register flag at 1, every byte takes the new result and every write enable is 1. Length, predicates and policies are ignored, and the active output marks all elements below VLEN/SEW.
- R9: A byte whose write enable is 0 carries the old destination byte.
- R10: The width code selects 8, 16, 32 or 64 bits for codes 0, 1, 2 and 3. Element i covers bytes i*SEW/8 to (i+1)*SEW/8-1, and active bits at or above VLEN/SEW are 0.
- R11: Outputs are registered and valid one cycle after a request. Under reset, or on a cycle with no request, out_valid, all write enables and all active bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| new_vec | input | VLEN | Newly computed result register |
| old_vec | input | VLEN | Previous destination contents |
| mask_bits | input | VLEN/8 | One predicate bit per element, bit i for element i |
| vl | input | log2(VLEN/8)+1 | Requested element count |
| sew_sel | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| mask_en | input | 1 | Instruction uses predication |
| tail_agn | input | 1 | Tail policy: 1 fill with ones, 0 keep old |
| mask_agn | input | 1 | Predicate policy: 1 fill with ones, 0 keep old |
| whole_reg | input | 1 | Full-width transfer ignoring length and predicates |
| out_valid | output | 1 | Merged result valid |
| merged | output | VLEN | Merged destination value |
| byte_we | output | VLEN/8 | Per-byte write enable |
| lane_active | output | VLEN/8 | Per-element active flag |

## Verification
Tail handling and predicate handling act on the same register in the same cycle. The interesting case is a request where the length is shorter than the element count while predication is on and the two policy bits differ. In that case one output word holds new, kept and filled elements at once. Random requests draw length, predicates, width and both policies independently, and directed cases set opposite policies with mixed predicates. Every byte, enable and active bit is compared against a bench model derived from the requirements, so a fill leaking into a kept region, or the reverse, shows up in the exact element where it happens.

// File: rtl/sxm_pkg.sv
package sxm_pkg;

    typedef enum logic [1:0] {
        SEW_E8  = 2'd0,
        SEW_E16 = 2'd1,
        SEW_E32 = 2'd2,
        SEW_E64 = 2'd3
    } sew_e;

    typedef enum logic [1:0] {
        SRC_NEW  = 2'd0,
        SRC_OLD  = 2'd1,
        SRC_FILL = 2'd2
    } src_e;

    typedef struct packed {
        logic body;
        logic active;
    } lane_cls_t;

    // Source selection for one element, given its class and the policies.
    function automatic src_e pick_src(input logic whole,
                                      input lane_cls_t c,
                                      input logic tail_fill,
                                      input logic pred_fill);
        if (whole || c.active) begin
            return SRC_NEW;
        end
        if (c.body) begin
            return pred_fill ? SRC_FILL : SRC_OLD;
        end
        return tail_fill ? SRC_FILL : SRC_OLD;
    endfunction

    // A byte is written whenever its source is not the old value.
    function automatic logic src_writes(input src_e s);
        return (s != SRC_OLD);
    endfunction

endpackage

// File: rtl/sxm_elem_class.sv
module sxm_elem_class
    import sxm_pkg::*;
#(
    parameter int MAXL = 16,
    parameter int VLW  = 5
) (
    input  logic [VLW-1:0]       vl,
    input  sew_e                 sew,
    input  logic [MAXL-1:0]      mask_bits,
    input  logic                 mask_en,
    input  logic                 whole,
    output lane_cls_t [MAXL-1:0] cls,
    output logic [MAXL-1:0]      act_vec
);

    logic [VLW-1:0] vlmax;
    logic [VLW-1:0] vl_eff;

    always_comb begin
        vlmax  = VLW'(MAXL >> sew);
        vl_eff = (vl > vlmax) ? vlmax : vl;
    end

    for (genvar i = 0; i < MAXL; i++) begin : g_lane
        localparam logic [VLW-1:0] IDX = VLW'(i);
        always_comb begin
            cls[i].body   = (IDX < vl_eff);
            cls[i].active = cls[i].body && (mask_bits[i] || !mask_en);
            if (whole) begin
                act_vec[i] = (IDX < vlmax);
            end else begin
                act_vec[i] = cls[i].active;
            end
        end
    end

endmodule

// File: rtl/sxm_byte_merge.sv
module sxm_byte_merge
    import sxm_pkg::*;
#(
    parameter int MAXL = 16
) (
    input  sew_e                  sew,
    input  lane_cls_t [MAXL-1:0]  cls,
    input  logic                  whole,
    input  logic                  tail_fill,
    input  logic                  pred_fill,
    input  logic [MAXL*8-1:0]     new_vec,
    input  logic [MAXL*8-1:0]     old_vec,
    output logic [MAXL*8-1:0]     merged,
    output logic [MAXL-1:0]       byte_we
);

    localparam int LIW = (MAXL > 1) ? $clog2(MAXL) : 1;

    for (genvar b = 0; b < MAXL; b++) begin : g_byte
        localparam int BI = b;
        logic [LIW-1:0] eidx;
        lane_cls_t      c;
        src_e           s;

        always_comb begin
            eidx = LIW'(BI >> sew);
            c    = cls[eidx];
            s    = pick_src(whole, c, tail_fill, pred_fill);
            unique case (s)
                SRC_NEW:  merged[b*8 +: 8] = new_vec[b*8 +: 8];
                SRC_FILL: merged[b*8 +: 8] = 8'hFF;
                default:  merged[b*8 +: 8] = old_vec[b*8 +: 8];
            endcase
            byte_we[b] = src_writes(s);
        end
    end

endmodule

// File: rtl/sxm_merge.sv
module sxm_merge
    import sxm_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int MAXL = VLEN / 8,
    localparam int VLW  = $clog2(MAXL) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [VLEN-1:0]   new_vec,
    input  logic [VLEN-1:0]   old_vec,
    input  logic [MAXL-1:0]   mask_bits,
    input  logic [VLW-1:0]    vl,
    input  logic [1:0]        sew_sel,
    input  logic              mask_en,
    input  logic              tail_agn,
    input  logic              mask_agn,
    input  logic              whole_reg,
    output logic              out_valid,
    output logic [VLEN-1:0]   merged,
    output logic [MAXL-1:0]   byte_we,
    output logic [MAXL-1:0]   lane_active
);

    sew_e                 sew;
    lane_cls_t [MAXL-1:0] cls;
    logic [MAXL-1:0]      act_d;
    logic [VLEN-1:0]      merged_d;
    logic [MAXL-1:0]      we_d;

    assign sew = sew_e'(sew_sel);

    sxm_elem_class #(.MAXL(MAXL), .VLW(VLW)) u_class (
        .vl        (vl),
        .sew       (sew),
        .mask_bits (mask_bits),
        .mask_en   (mask_en),
        .whole     (whole_reg),
        .cls       (cls),
        .act_vec   (act_d)
    );

    sxm_byte_merge #(.MAXL(MAXL)) u_bytes (
        .sew       (sew),
        .cls       (cls),
        .whole     (whole_reg),
        .tail_fill (tail_agn),
        .pred_fill (mask_agn),
        .new_vec   (new_vec),
        .old_vec   (old_vec),
        .merged    (merged_d),
        .byte_we   (we_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            merged      <= '0;
            byte_we     <= '0;
            lane_active <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                merged      <= merged_d;
                byte_we     <= we_d;
                lane_active <= act_d;
            end else begin
                byte_we     <= '0;
                lane_active <= '0;
            end
        end
    end

endmodule

// File: rtl/sxm_merge_checker.sv
module sxm_merge_checker #(
    parameter int VLEN = 128,
    localparam int MAXL = VLEN / 8,
    localparam int VLW  = $clog2(MAXL) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic [VLEN-1:0] old_vec,
    input logic [MAXL-1:0] mask_bits,
    input logic [VLW-1:0]  vl,
    input logic [1:0]      sew_sel,
    input logic            mask_en,
    input logic            whole_reg,
    input logic            out_valid,
    input logic [VLEN-1:0] merged,
    input logic [MAXL-1:0] byte_we,
    input logic [MAXL-1:0] lane_active
);

    logic [VLEN-1:0] we_bits;
    for (genvar b = 0; b < MAXL; b++) begin : g_exp
        assign we_bits[b*8 +: 8] = {8{byte_we[b]}};
    end

    // R1: active lanes never outnumber the requested length
    p_active_in_body_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(whole_reg)) |-> ($countones(lane_active) <= $past(vl)));

    // R2: with predication on, no lane is active where its predicate bit is 0
    p_active_masked_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mask_en) && !$past(whole_reg)) |->
        ((lane_active & ~$past(mask_bits)) == '0));

    // R8: whole-register transfers enable every byte
    p_whole_all_we_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(whole_reg)) |-> (&byte_we));

    // R9: bytes without write enable hold the old destination
    p_unwritten_old_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((merged ^ $past(old_vec)) & ~we_bits) == '0));

    // R10: no active flag at or beyond the element count
    p_lane_within_vlmax_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((lane_active >> (MAXL >> $past(sew_sel))) == '0));

    // R11: idle cycles carry no enables and no active lanes
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (byte_we == '0 && lane_active == '0));

endmodule

bind sxm_merge sxm_merge_checker #(.VLEN(VLEN)) u_sxm_merge_checker (
    .clk         (clk),
    .rst         (rst),
    .old_vec     (old_vec),
    .mask_bits   (mask_bits),
    .vl          (vl),
    .sew_sel     (sew_sel),
    .mask_en     (mask_en),
    .whole_reg   (whole_reg),
    .out_valid   (out_valid),
    .merged      (merged),
    .byte_we     (byte_we),
    .lane_active (lane_active)
);

// File: tb/sxm_merge_bench.sv
module sxm_merge_bench;

    localparam int VLEN = 128;
    localparam int MAXL = VLEN / 8;
    localparam int VLW  = $clog2(MAXL) + 1;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [VLEN-1:0] new_vec, old_vec;
    logic [MAXL-1:0] mask_bits;
    logic [VLW-1:0]  vl;
    logic [1:0]      sew_sel;
    logic            mask_en, tail_agn, mask_agn, whole_reg;
    logic            out_valid;
    logic [VLEN-1:0] merged;
    logic [MAXL-1:0] byte_we, lane_active;

    logic [VLEN-1:0] exp_merged;
    logic [MAXL-1:0] exp_we, exp_act;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sxm_merge #(.VLEN(VLEN)) u_sxm_merge (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .new_vec(new_vec), .old_vec(old_vec), .mask_bits(mask_bits),
        .vl(vl), .sew_sel(sew_sel), .mask_en(mask_en),
        .tail_agn(tail_agn), .mask_agn(mask_agn), .whole_reg(whole_reg),
        .out_valid(out_valid), .merged(merged),
        .byte_we(byte_we), .lane_active(lane_active)
    );

    // Expected values from the requirements.
    task automatic model();
        int vm, vle;
        vm  = MAXL >> sew_sel;
        vle = (int'(vl) > vm) ? vm : int'(vl);
        for (int b = 0; b < MAXL; b++) begin
            int  e;
            bit  body, act;
            e    = b >> sew_sel;
            body = (e < vle);
            act  = body && (mask_bits[e] || !mask_en);
            if (whole_reg || act) begin
                exp_merged[b*8 +: 8] = new_vec[b*8 +: 8];
                exp_we[b] = 1'b1;
            end else if ((body && mask_agn) || (!body && tail_agn)) begin
                exp_merged[b*8 +: 8] = 8'hFF;
                exp_we[b] = 1'b1;
            end else begin
                exp_merged[b*8 +: 8] = old_vec[b*8 +: 8];
                exp_we[b] = 1'b0;
            end
        end
        for (int e = 0; e < MAXL; e++) begin
            if (whole_reg) exp_act[e] = (e < vm);
            else exp_act[e] = (e < vle) && (mask_bits[e] || !mask_en);
        end
    endtask

    task automatic check_vec(input string tag, input logic [VLEN-1:0] act,
                             input logic [VLEN-1:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(tag, VLEN'(out_valid), VLEN'(1'b1), "out_valid");
        check_vec(tag, merged, exp_merged, "merged");
        check_vec(tag, VLEN'(byte_we), VLEN'(exp_we), "byte_we");
        check_vec(tag, VLEN'(lane_active), VLEN'(exp_act), "lane_active");
    endtask

    function automatic logic [VLEN-1:0] rnd_vec();
        logic [VLEN-1:0] v;
        for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic setup(input logic [1:0] s, input int l, input logic [MAXL-1:0] m,
                         input logic men, input logic ta, input logic ma, input logic wh);
        new_vec = rnd_vec(); old_vec = rnd_vec();
        sew_sel = s; vl = VLW'(l); mask_bits = m;
        mask_en = men; tail_agn = ta; mask_agn = ma; whole_reg = wh;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; in_valid = 1'b0;
        setup(2'd0, 0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check_vec("R11", VLEN'(out_valid), '0, "reset out_valid");
        check_vec("R11", VLEN'(byte_we), '0, "reset byte_we");
        check_vec("R11", VLEN'(lane_active), '0, "reset lane_active");
        rst = 1'b0;

        // R1: length 5 of 8 elements (16-bit), tail kept
        setup(2'd1, 5, '1, 1'b0, 1'b0, 1'b0, 1'b0); apply("R1");
        // R1: requested length above element count is clamped
        setup(2'd2, 31, '1, 1'b0, 1'b1, 1'b1, 1'b0); apply("R1");
        // R3: length 0, all tail kept
        setup(2'd0, 0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0); apply("R3");
        // R4: tail filled with ones
        setup(2'd0, 9, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0); apply("R4");
        // R5: predicate kept, alternating predicates
        setup(2'd0, 16, 16'hA5A5, 1'b1, 1'b0, 1'b0, 1'b0); apply("R5");
        // R6: predicate fill
        setup(2'd1, 8, 16'h0033, 1'b1, 1'b0, 1'b1, 1'b0); apply("R6");
        // R2: predication off ignores predicate bits
        setup(2'd1, 6, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0); apply("R2");
        // R7: all active
        setup(2'd3, 2, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0); apply("R7");
        // R8: whole register ignores length and predicates
        setup(2'd2, 1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1); apply("R8");
        // R10: 64-bit elements with mixed policies
        setup(2'd3, 1, 16'hFFFE, 1'b1, 1'b1, 1'b0, 1'b0); apply("R10");
        // R9: opposite policies in one word
        setup(2'd2, 3, 16'h0005, 1'b1, 1'b0, 1'b1, 1'b0); apply("R9");
        setup(2'd2, 3, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b0); apply("R9");

        // R11: idle cycle after a request clears enables
        @(negedge clk);
        check_vec("R11", VLEN'(out_valid), '0, "idle out_valid");
        check_vec("R11", VLEN'(byte_we), '0, "idle byte_we");
        check_vec("R11", VLEN'(lane_active), '0, "idle lane_active");

        // R7 R9 R10: random mix
        for (int n = 0; n < 400; n++) begin
            setup(2'($urandom_range(0, 3)), $urandom_range(0, 31),
                  MAXL'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom_range(0, 9) == 0));
            apply("R7");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule